// File: doc/BRIEF.md
# Serial Byte Receiver with Sticky Status Flags

This block turns an asynchronous serial line into bytes. It oversamples the line with a baud tick at sixteen ticks per bit. It confirms a start bit at mid-bit and shifts in eight data bits, least significant first. An optional parity bit follows, then one stop bit. After the stop bit is sampled, the assembled byte moves into a single-entry receive buffer.

A small status word reports the receiver's progress and results:
- a busy bit that cannot be written;
- four sticky flags, cleared by software through a write-one-to-clear port: buffer full, parity error, framing error and overrun.

Two level interrupt requests follow the flags through their own enable inputs. One is for buffer full. The other is shared by the three error flags.

The received byte leaves as plain data qualified by the buffer-full flag. It is not a valid/ready stream. The line cannot be stalled, so the receiver applies no back-pressure: a byte that arrives while the buffer is still full overwrites it and raises the overrun flag. The baud tick, parity enable and parity sense are inputs. They are expected to stay constant for the duration of a frame.

Top module: `srx_status_top`

## Requirements
- R1: Busy (status bit 4) rises when a start bit is confirmed at mid-bit. It falls on the same clock edge that loads the byte into the receive buffer.
- R2: A low pulse that returns high before the mid-bit sample of the start bit is discarded. Busy stays 0 and no byte is loaded.
- R3: A frame is a start bit, 8 data bits least significant first, a parity bit only when parity enable is 1, and one stop bit. The data bits appear on rx_data_o when the byte is loaded.
- R4: The buffer-full flag (status bit 0) sets on every load. irq_full_o is high whenever that flag is set and ie_full_i is 1, including the cycle in which the flag is set.
- R5: With parity enable at 1, a load sets the parity error flag (status bit 1) when the received parity bit gives an odd count of ones over data plus parity while parity sense is even (par_odd_i = 0), or an even count while parity sense is odd (par_odd_i = 1). With parity enable at 0, that flag never sets.
- R6: A load whose stop bit samples 0 sets the framing error flag (status bit 2). After such a frame, a new start is accepted only once the line has been seen high.
- R7: A load that happens while buffer full is still set sets the overrun flag (status bit 3). The new byte replaces the old one on rx_data_o.
- R8: irq_err_o is high whenever any of status bits 1, 2 or 3 is set and ie_err_i is 1. It is low otherwise.
- R9: When wr_en_i is 1, each 1 in wr_data_i[3:0] clears the flag at the same position in status_o[3:0], and each 0 leaves that flag unchanged. Busy has no write bit.
- R10: When a clear and a hardware set hit the same flag in the same cycle, the flag ends up set.
- R11: After reset, all flags and busy are 0, rx_data_o is 0 and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| baud_tick_i | input | 1 | One-cycle pulse, sixteen per bit time |
| par_en_i | input | 1 | 1 = frame carries a parity bit and parity is checked |
| par_odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| ie_full_i | input | 1 | Enable for irq_full_o |
| ie_err_i | input | 1 | Enable for irq_err_o |
| wr_en_i | input | 1 | Write strobe for the clear mask |
| wr_data_i | input | 4 | Clear mask: bit 0 full, 1 parity, 2 framing, 3 overrun |
| rx_data_o | output | 8 | Receive buffer contents |
| status_o | output | 5 | Bit 0 full, 1 parity err, 2 framing err, 3 overrun, 4 busy |
| irq_full_o | output | 1 | Buffer-full interrupt request (level) |
| irq_err_o | output | 1 | Receive-error interrupt request (level) |

## Verification
Two things can land on the same flag in the same cycle: a hardware load that sets buffer full, and a software write that clears it. The bench holds a clear of bit 0 through the whole stop bit and releases it only after busy drops. This puts the write on the exact edge that loads the byte. The scoreboard then expects buffer full still set after the write ends, and the flag must stay set until an explicit later clear. A further case pairs a load with an unread buffer, where overrun and buffer full must both be set by the same edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int FLAG_W   = 4;
  localparam int STAT_W   = FLAG_W + 1;
  localparam int F_FULL   = 0;
  localparam int F_PERR   = 1;
  localparam int F_FERR   = 2;
  localparam int F_OVR    = 3;
  localparam int S_BUSY   = FLAG_W;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             tick_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  output logic             busy_o,
  output logic             ld_o,
  output logic [DBITS-1:0] ld_data_o,
  output logic             par_bad_o,
  output logic             stop_bad_o
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] TOPB = BW'(DBITS - 1);

  rx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [BW-1:0]    bit_q;
  logic [DBITS-1:0] sh_q;
  logic             par_q;
  logic             busy_q;
  logic             armed_q;
  logic             at_end;

  assign at_end = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      case (state_q)
        RX_IDLE: begin
          if (rx_i) begin
            armed_q <= 1'b1;
          end else if (armed_q) begin
            state_q <= RX_START;
            cnt_q   <= '0;
            armed_q <= 1'b0;
          end
        end
        RX_START: begin
          if (rx_i) begin
            state_q <= RX_IDLE;
            armed_q <= 1'b1;
          end else if (cnt_q == MID) begin
            state_q <= RX_DATA;
            cnt_q   <= '0;
            bit_q   <= '0;
            busy_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_end) begin
            sh_q  <= {rx_i, sh_q[DBITS-1:1]};
            cnt_q <= '0;
            if (bit_q == TOPB) state_q <= par_en_i ? RX_PAR : RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_end) begin
            par_q   <= rx_i;
            cnt_q   <= '0;
            state_q <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_end) begin
            state_q <= RX_IDLE;
            busy_q  <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign ld_o       = tick_i && (state_q == RX_STOP) && at_end;
  assign ld_data_o  = sh_q;
  assign stop_bad_o = ~rx_i;
  assign par_bad_o  = par_en_i & (par_q ^ (^sh_q) ^ par_odd_i);
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
#(
  parameter int DBITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [DBITS-1:0]  ld_data_i,
  input  logic              par_bad_i,
  input  logic              stop_bad_i,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] wr_mask_i,
  input  logic              ie_full_i,
  input  logic              ie_err_i,
  output logic [DBITS-1:0]  data_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_full_o,
  output logic              irq_err_o
);
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;
  logic [DBITS-1:0]  buf_q;

  always_comb begin
    set_v         = '0;
    set_v[F_FULL] = ld_i;
    set_v[F_PERR] = ld_i & par_bad_i;
    set_v[F_FERR] = ld_i & stop_bad_i;
    set_v[F_OVR]  = ld_i & flag_q[F_FULL];
    clr_v         = wr_en_i ? wr_mask_i : '0;
  end

  generate
    for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[f] <= 1'b0;
        else        flag_q[f] <= (flag_q[f] & ~clr_v[f]) | set_v[f];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    buf_q <= '0;
    else if (ld_i) buf_q <= ld_data_i;
  end

  assign data_o     = buf_q;
  assign flags_o    = flag_q;
  assign irq_full_o = ie_full_i & flag_q[F_FULL];
  assign irq_err_o  = ie_err_i & (flag_q[F_PERR] | flag_q[F_FERR] | flag_q[F_OVR]);
endmodule

// File: rtl/srx_status_top.sv
module srx_status_top
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              baud_tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              ie_full_i,
  input  logic              ie_err_i,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] wr_data_i,
  output logic [DBITS-1:0]  rx_data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_full_o,
  output logic              irq_err_o
);
  logic              rx_s;
  logic              busy;
  logic              ld;
  logic [DBITS-1:0]  ld_data;
  logic              par_bad;
  logic              stop_bad;
  logic [FLAG_W-1:0] flags;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  srx_framer #(.OVS(OVS), .DBITS(DBITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_s), .tick_i(baud_tick_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .busy_o(busy),
    .ld_o(ld), .ld_data_o(ld_data), .par_bad_o(par_bad), .stop_bad_o(stop_bad)
  );

  srx_flags #(.DBITS(DBITS)) u_flags (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_data_i(ld_data),
    .par_bad_i(par_bad), .stop_bad_i(stop_bad), .wr_en_i(wr_en_i),
    .wr_mask_i(wr_data_i), .ie_full_i(ie_full_i), .ie_err_i(ie_err_i),
    .data_o(rx_data_o), .flags_o(flags), .irq_full_o(irq_full_o),
    .irq_err_o(irq_err_o)
  );

  assign status_o = {busy, flags};
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld,
  input logic [DBITS-1:0] ld_data,
  input logic [4:0]       status,
  input logic [DBITS-1:0] rx_data,
  input logic             wr_en,
  input logic [3:0]       wr_data,
  input logic             ie_full,
  input logic             irq_full
);
  p_busy_falls_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(ld));

  p_load_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !status[4]);

  p_full_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> status[0]);

  p_irq_full_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ie_full) |=> (irq_full || !ie_full));

  p_overrun_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && status[0]) |=> status[3]);

  p_data_replaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (rx_data == $past(ld_data)));

  p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(wr_en && wr_data[0])) |=> status[0]);

  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(wr_en && wr_data[1])) |=> status[1]);
endmodule

bind srx_status_top srx_checker #(.DBITS(DBITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .ld_data(ld_data), .status(status_o),
  .rx_data(rx_data_o), .wr_en(wr_en_i), .wr_data(wr_data_i),
  .ie_full(ie_full_i), .irq_full(irq_full_o)
);

// File: tb/test_srx_status_top.sv
module test_srx_status_top;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx, tick, par_en, par_odd, ie_full, ie_err, wr_en;
  logic [3:0] wr_data;
  logic [7:0] rx_data;
  logic [4:0] status;
  logic       irq_full, irq_err;

  typedef struct {
    logic [7:0] data;
    logic [3:0] flg;
    bit         keep;
  } item_t;
  item_t sb_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  srx_status_top i_srx_status_top (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd), .ie_full_i(ie_full),
    .ie_err_i(ie_err), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rx_data_o(rx_data), .status_o(status), .irq_full_o(irq_full),
    .irq_err_o(irq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    tick = 1'b0;
    forever @(negedge clk) tick = ~tick;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
  end

  task automatic bit_out(input logic b);
    rx = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic expect_frame(input logic [7:0] d, input logic [3:0] f, input bit keep);
    item_t it;
    it.data = d; it.flg = f; it.keep = keep;
    sb_q.push_back(it);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input logic stop, input bit hold_clr);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (par_en) bit_out((^d) ^ par_odd ^ bad_par);
    if (hold_clr) begin
      wr_data = 4'h1;
      wr_en   = 1'b1;
    end
    rx = stop;
    for (int i = 0; i < BITCLK; i++) begin
      @(negedge clk);
      if (hold_clr && !status[4]) wr_en = 1'b0;
    end
    bit_out(1'b1);
    bit_out(1'b1);
    bit_out(1'b1);
  endtask

  task automatic wr_clear(input logic [3:0] m);
    wr_data = m;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Monitor: a falling busy marks a load; compare against the scoreboard
  initial begin
    bit prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && prev_busy && !status[4]) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 unexpected load", rx_data, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(rx_data == it.data, "R3 data", rx_data, it.data);
          chk(status[3:0] == it.flg, "R5/R6/R7 flags", status[3:0], it.flg);
          chk(irq_full == (it.flg[0] & ie_full), "R4 irq_full", irq_full, it.flg[0] & ie_full);
          chk(irq_err == ((|it.flg[3:1]) & ie_err), "R8 irq_err", irq_err, (|it.flg[3:1]) & ie_err);
          if (!it.keep) wr_clear(4'hF);
        end
      end
      prev_busy = status[4];
    end
  end

  initial begin
    bit seen_busy;
    rst_n = 1'b0; rx = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    ie_full = 1'b1; ie_err = 1'b1; wr_en = 1'b0; wr_data = 4'h0;
    repeat (5) @(negedge clk);
    chk(status == 5'h00, "R11 status", status, 0);
    chk(rx_data == 8'h00, "R11 data", rx_data, 0);
    chk(irq_full == 1'b0 && irq_err == 1'b0, "R11 irq", {irq_full, irq_err}, 0);
    rst_n = 1'b1;
    repeat (BITCLK) @(negedge clk);

    // R3: no parity bit
    expect_frame(8'hA5, 4'b0001, 0); send_frame(8'hA5, 0, 1'b1, 0);
    // R1: busy observed mid-frame
    fork
      begin expect_frame(8'h3C, 4'b0001, 0); par_en = 1'b1; send_frame(8'h3C, 0, 1'b1, 0); end
      begin repeat (4*BITCLK) @(negedge clk);
            chk(status[4] == 1'b1, "R1 busy mid-frame", status[4], 1); end
    join
    // R5: odd parity, good
    par_odd = 1'b1;
    expect_frame(8'h81, 4'b0001, 0); send_frame(8'h81, 0, 1'b1, 0);
    // R5: even parity, bad, kept for clear tests
    par_odd = 1'b0; ie_full = 1'b0;
    expect_frame(8'h5A, 4'b0011, 1); send_frame(8'h5A, 1, 1'b1, 0);
    // R9: zero writes ignored, ones clear per bit
    wr_clear(4'h0);
    chk(status[3:0] == 4'b0011, "R9 zero write", status[3:0], 4'b0011);
    wr_clear(4'h2);
    chk(status[3:0] == 4'b0001, "R9 clear parity", status[3:0], 4'b0001);
    chk(irq_err == 1'b0, "R8 irq_err drops", irq_err, 0);
    wr_clear(4'h1);
    chk(status[3:0] == 4'b0000, "R9 clear full", status[3:0], 0);
    ie_full = 1'b1;
    // R6: framing error, then recovery
    expect_frame(8'h0F, 4'b0101, 0); send_frame(8'h0F, 0, 1'b0, 0);
    expect_frame(8'hF0, 4'b0001, 0); send_frame(8'hF0, 0, 1'b1, 0);
    // R7: overrun
    expect_frame(8'h11, 4'b0001, 1); send_frame(8'h11, 0, 1'b1, 0);
    expect_frame(8'h22, 4'b1001, 0); send_frame(8'h22, 0, 1'b1, 0);
    // R10: clear held across the load edge
    expect_frame(8'h33, 4'b0001, 1); send_frame(8'h33, 0, 1'b1, 0);
    expect_frame(8'h44, 4'b0001, 1); send_frame(8'h44, 0, 1'b1, 1);
    chk(status[0] == 1'b1, "R10 set wins", status[0], 1);
    wr_clear(4'hF);
    chk(status[3:0] == 4'h0, "R10 later clear", status[3:0], 0);
    // R2: glitch shorter than half a bit
    seen_busy = 1'b0;
    rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    for (int i = 0; i < 3*BITCLK; i++) begin
      @(negedge clk);
      if (status[4]) seen_busy = 1'b1;
    end
    chk(seen_busy == 1'b0, "R2 glitch busy", seen_busy, 0);
    chk(status == 5'h00, "R2 glitch flags", status, 0);
    // R4/R8: enables off gate both requests
    ie_full = 1'b0; ie_err = 1'b0;
    expect_frame(8'h77, 4'b0101, 0); send_frame(8'h77, 0, 1'b0, 0);
    repeat (BITCLK) @(negedge clk);
    chk(sb_q.size() == 0, "R3 all frames loaded", sb_q.size(), 0);
    summary();
  end
endmodule